// File: doc/BRIEF.md
# PLL Band Calibration Sequencer

This block runs a one-shot calibration of the 6-bit VCO band field of a PLL after start-up or reset. It reads the configuration word that holds the field and rewrites it with the band field set to the auto-search code. It then waits for the PLL lock input, bounded by a timeout. When lock arrives, it reads back the band that the hardware search chose and shifts it by an offset. The offset depends on the start-up temperature and on whether the chosen band lies in the lower or the upper half of the range. Last, it writes the corrected band back into the same field.

The block reaches the PLL configuration through a simple register port. A read returns its data one cycle after the read strobe. Every write is a read-modify-write, so the divider fields and all other bits of the configuration word keep their values. The reference clock of the PLL must run for the whole sequence. The states are, in order: IDLE, RD_CFG, RD_CFG_W, WR_AUTO, WAIT_LOCK, RD_BAND, RD_BAND_W, WR_FINAL, then DONE (success) or FAIL (timeout). The transitions are:
- IDLE→RD_CFG on an accepted start.
- RD_CFG→RD_CFG_W→WR_AUTO→WAIT_LOCK, unconditionally.
- WAIT_LOCK→RD_BAND when lock is high.
- WAIT_LOCK→FAIL when the timer expires.
- RD_BAND→RD_BAND_W→WR_FINAL→DONE.
- DONE→IDLE and FAIL→IDLE, unconditionally.

Top module: `pll_band_cal`

## Requirements
- R1: A start pulse seen in IDLE issues a read of configuration address 4 in the next cycle. The read data is taken one cycle after the read strobe.
- R2: The block then writes address 4 with bits [7:2] = 63 (auto code). All other bits equal the value read.
- R3: After the auto write, the block waits for lock_in high. It then re-reads address 4 and takes bits [7:2] as the chosen band.
- R4: If lock_in stays low for TIMEOUT_US microseconds of CLK_HZ cycles, the block raises error and pulses done. It makes no further access, and band_out keeps its previous value.
- R5: For a chosen band 0–31, the offset is +2 below −10 °C, +1 from −10 to 14 °C, 0 from 15 to 54 °C, and −1 from 55 °C up.
- R6: For a chosen band 32–63, the offset is +3 below −30 °C and +2 from −30 to −11 °C. From −10 °C up, the offsets of R5 apply.
- R7: temp_c is signed 8-bit whole °C, sampled on the accepted start and clamped to −40..85 °C.
- R8: The corrected band saturates to 0..62, so it never equals 63.
- R9: The final write puts the corrected band in bits [7:2] of address 4 and keeps all other bits as re-read. band_out takes the corrected band, and done is high for exactly one cycle.
- R10: start is ignored while a calibration runs. There is exactly one auto write and one final write per run.
- R11: error stays high until the next accepted start, which clears it.
- R12: After reset, done, error, band_out, reg_we and reg_re are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration (ignored when busy) |
| temp_c | input | 8 | Signed start-up temperature, °C |
| lock_in | input | 1 | PLL lock indication |
| reg_we | output | 1 | Register write strobe |
| reg_re | output | 1 | Register read strobe |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | DATA_W | Register write data |
| reg_rdata | input | DATA_W | Read data, valid one cycle after reg_re |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Lock timeout flag, held until next start |
| band_out | output | 6 | Last corrected band |

## Verification
A wrong state shows at the register port within one or two cycles. The symptoms are a missing or extra strobe, a write before the read it depends on, or a corrupted divider field in the written word. A wrong offset or clamp only shows in the final write and band_out, at the end of the run. For that reason, every chosen band class is swept across all 256 temperature codes. A stuck timer shows as a done pulse arriving outside the expected latency window.

// File: rtl/pll_band_cal_pkg.sv
package pll_band_cal_pkg;
    localparam int BAND_W    = 6;
    localparam int BAND_LSB  = 2;
    localparam int AUTO_CODE = 63;
    localparam int BAND_MAX  = 62;
    localparam int CFG_ADDR  = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_CFG,
        ST_RD_CFG_W,
        ST_WR_AUTO,
        ST_WAIT_LOCK,
        ST_RD_BAND,
        ST_RD_BAND_W,
        ST_WR_FINAL,
        ST_DONE,
        ST_FAIL
    } cal_state_t;
endpackage

// File: rtl/band_offset.sv
module band_offset
    import pll_band_cal_pkg::*;
(
    input  logic signed [7:0]  temp_c,
    input  logic [BAND_W-1:0]  band_in,
    output logic [BAND_W-1:0]  band_corr
);
    logic signed [7:0] t_cl;
    logic signed [3:0] offs;
    logic signed [8:0] sum;
    logic              upper;

    always_comb begin
        if (temp_c < -8'sd40)      t_cl = -8'sd40;
        else if (temp_c > 8'sd85)  t_cl = 8'sd85;
        else                       t_cl = temp_c;
    end

    assign upper = band_in[BAND_W-1];

    always_comb begin
        if (t_cl >= 8'sd55)       offs = -4'sd1;
        else if (t_cl >= 8'sd15)  offs = 4'sd0;
        else if (t_cl >= -8'sd10) offs = 4'sd1;
        else if (upper && t_cl < -8'sd30) offs = 4'sd3;
        else                      offs = 4'sd2;
    end

    always_comb begin
        sum = $signed({3'b000, band_in}) + {{5{offs[3]}}, offs};
        if (sum < 9'sd0)                   band_corr = '0;
        else if (sum > 9'(BAND_MAX))       band_corr = BAND_W'(BAND_MAX);
        else                               band_corr = sum[BAND_W-1:0];
    end
endmodule

// File: rtl/lock_timer.sv
module lock_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (clear)          cnt <= '0;
        else if (run && !expired) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt >= CNT_W'(CYCLES - 1));
endmodule

// File: rtl/pll_band_cal.sv
module pll_band_cal
    import pll_band_cal_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int CLK_HZ     = 200_000_000,
    parameter int TIMEOUT_US = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic signed [7:0] temp_c,
    input  logic              lock_in,
    output logic              reg_we,
    output logic              reg_re,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              done,
    output logic              error,
    output logic [5:0]        band_out
);
    localparam int TIMEOUT_CYC = (CLK_HZ / 1_000_000) * TIMEOUT_US;
    localparam logic [DATA_W-1:0] BAND_MASK =
        DATA_W'(((1 << BAND_W) - 1) << BAND_LSB);

    cal_state_t        state, nxt;
    logic [DATA_W-1:0] cfg_q;
    logic [BAND_W-1:0] rb_q;
    logic signed [7:0] temp_q;
    logic [BAND_W-1:0] corr;
    logic              tmr_clr, tmr_exp;

    band_offset u_offset (
        .temp_c    (temp_q),
        .band_in   (rb_q),
        .band_corr (corr)
    );

    lock_timer #(.CYCLES(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clr),
        .run     (state == ST_WAIT_LOCK),
        .expired (tmr_exp)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (start) nxt = ST_RD_CFG;
            ST_RD_CFG:    nxt = ST_RD_CFG_W;
            ST_RD_CFG_W:  nxt = ST_WR_AUTO;
            ST_WR_AUTO:   nxt = ST_WAIT_LOCK;
            ST_WAIT_LOCK: begin
                if (lock_in)      nxt = ST_RD_BAND;
                else if (tmr_exp) nxt = ST_FAIL;
            end
            ST_RD_BAND:   nxt = ST_RD_BAND_W;
            ST_RD_BAND_W: nxt = ST_WR_FINAL;
            ST_WR_FINAL:  nxt = ST_DONE;
            ST_DONE:      nxt = ST_IDLE;
            ST_FAIL:      nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            rb_q     <= '0;
            temp_q   <= '0;
            error    <= 1'b0;
            band_out <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                temp_q <= temp_c;
                error  <= 1'b0;
            end
            if (state == ST_RD_CFG_W || state == ST_RD_BAND_W)
                cfg_q <= reg_rdata;
            if (state == ST_RD_BAND_W)
                rb_q <= reg_rdata[BAND_LSB +: BAND_W];
            if (state == ST_WAIT_LOCK && !lock_in && tmr_exp)
                error <= 1'b1;
            if (state == ST_WR_FINAL)
                band_out <= corr;
        end
    end

    always_comb begin
        reg_we    = 1'b0;
        reg_re    = 1'b0;
        reg_addr  = ADDR_W'(CFG_ADDR);
        reg_wdata = '0;
        done      = 1'b0;
        tmr_clr   = 1'b0;
        unique case (state)
            ST_IDLE:      ;
            ST_RD_CFG:    reg_re = 1'b1;
            ST_RD_CFG_W:  ;
            ST_WR_AUTO: begin
                reg_we    = 1'b1;
                reg_wdata = (cfg_q & ~BAND_MASK) | (DATA_W'(AUTO_CODE) << BAND_LSB);
                tmr_clr   = 1'b1;
            end
            ST_WAIT_LOCK: ;
            ST_RD_BAND:   reg_re = 1'b1;
            ST_RD_BAND_W: ;
            ST_WR_FINAL: begin
                reg_we    = 1'b1;
                reg_wdata = (cfg_q & ~BAND_MASK) | (DATA_W'(corr) << BAND_LSB);
            end
            ST_DONE:      done = 1'b1;
            ST_FAIL:      done = 1'b1;
            default:      ;
        endcase
    end
endmodule

// File: rtl/pll_band_cal_chk.sv
module pll_band_cal_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              reg_we,
    input logic              reg_re,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              done,
    input logic              error,
    input logic [5:0]        band_out
);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_band_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        band_out <= 6'd62);
    assert_no_rw_clash_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));
    assert_cfg_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || reg_re) |-> reg_addr == ADDR_W'(4));
    assert_error_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> done);
    assert_error_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);
    assert_no_access_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(reg_we || reg_re));
endmodule

bind pll_band_cal pll_band_cal_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .reg_addr (reg_addr),
    .done     (done),
    .error    (error),
    .band_out (band_out)
);

// File: tb/test_pll_band_cal.sv
module test_pll_band_cal;
    localparam int TMO = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic signed [7:0] temp_c = '0;
    logic              lock_in = 1'b0;
    logic              reg_we, reg_re;
    logic [7:0]        reg_addr;
    logic [15:0]       reg_wdata;
    logic [15:0]       reg_rdata = '0;
    logic              done, error;
    logic [5:0]        band_out;

    int checks = 0;
    int errors = 0;

    logic [15:0] cfg = '0;
    logic [15:0] last_wd = '0;
    int          wr_cnt = 0;
    int          auto_cnt = 0;
    int          dly = -1;
    logic [5:0]  auto_band = '0;
    bit          auto_en = 1'b1;

    always #2.5 clk = ~clk;

    pll_band_cal #(.CLK_HZ(1_000_000), .TIMEOUT_US(TMO)) i_pll_band_cal (
        .clk(clk), .rst_n(rst_n), .start(start), .temp_c(temp_c),
        .lock_in(lock_in), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .done(done), .error(error), .band_out(band_out)
    );

    // register and PLL model
    always @(posedge clk) begin
        if (reg_re) reg_rdata <= (reg_addr == 8'd4) ? cfg : 16'h0000;
        if (reg_we) begin
            wr_cnt  <= wr_cnt + 1;
            last_wd <= reg_wdata;
            if (reg_addr == 8'd4) cfg <= reg_wdata;
            if (reg_wdata[7:2] == 6'd63) begin
                auto_cnt <= auto_cnt + 1;
                lock_in  <= 1'b0;
                dly      <= auto_en ? 3 : -1;
            end
        end else if (dly > 0) begin
            dly <= dly - 1;
        end else if (dly == 0) begin
            cfg[7:2] <= auto_band;
            lock_in  <= 1'b1;
            dly      <= -1;
        end
    end

    function automatic int exp_band(input int b, input int t);
        int tc, off, s;
        tc = (t < -40) ? -40 : ((t > 85) ? 85 : t);
        if (tc >= 55)       off = -1;
        else if (tc >= 15)  off = 0;
        else if (tc >= -10) off = 1;
        else if (b >= 32 && tc < -30) off = 3;
        else off = 2;
        s = b + off;
        if (s < 0) s = 0;
        if (s > 62) s = 62;
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int b, input int t, input bit lock_ok,
                       input bit extra_start, input logic [15:0] base,
                       output int lat);
        int n;
        @(negedge clk);
        cfg      = base;
        auto_band = 6'(b);
        auto_en  = lock_ok;
        temp_c   = 8'(t);
        wr_cnt   = 0;
        auto_cnt = 0;
        start    = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        temp_c = 8'(t + 97);          // later changes must not matter (R7)
        chk(error == 1'b0, "R11", int'(error), 0);
        n = 1;
        while (!done && n < 200) begin
            if (extra_start && n == 5) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        lat = n;
        chk(done == 1'b1, "R9", int'(done), 1);
        @(negedge clk);
        chk(done == 1'b0, "R9", int'(done), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lat, e, prev;
        int bands[8] = '{0, 1, 15, 31, 32, 33, 50, 62};
        logic [15:0] base;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(done == 0 && error == 0 && band_out == 0, "R12", int'(band_out), 0);
        chk(reg_we == 0 && reg_re == 0, "R12", int'(reg_we), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(reg_we == 0 && reg_re == 0 && done == 0, "R12", int'(reg_re), 0);

        // R5 R6 R7 R8 R9 R2 R3 sweep
        foreach (bands[i]) begin
            for (int t = -128; t < 128; t++) begin
                base = 16'h6B01 ^ 16'((i * 16'h1357) + t);
                run(bands[i], t, 1'b1, 1'b0, base, lat);
                e = exp_band(bands[i], t);
                chk(int'(band_out) == e, "R5/R6 band_out", int'(band_out), e);
                chk(int'(last_wd[7:2]) == e, "R9 field", int'(last_wd[7:2]), e);
                chk((last_wd & 16'hFF03) == (base & 16'hFF03), "R2/R9 keep",
                    int'(last_wd), int'(base));
                chk(wr_cnt == 2 && auto_cnt == 1, "R3 writes", wr_cnt, 2);
                chk(error == 1'b0, "R4 no error", int'(error), 0);
            end
        end

        // R10 start while busy
        run(40, 20, 1'b1, 1'b1, 16'h7A55, lat);
        chk(wr_cnt == 2, "R10 writes", wr_cnt, 2);
        chk(auto_cnt == 1, "R10 auto", auto_cnt, 1);
        chk(int'(band_out) == 40, "R10 band", int'(band_out), 40);
        repeat (4) @(negedge clk);
        chk(reg_we == 0 && reg_re == 0, "R10 idle", int'(reg_re), 0);

        // R4 timeout
        prev = int'(band_out);
        run(10, 0, 1'b0, 1'b0, 16'h1234, lat);
        chk(error == 1'b1, "R4 error", int'(error), 1);
        chk(lat >= TMO + 2 && lat <= TMO + 6, "R4 latency", lat, TMO + 4);
        chk(wr_cnt == 1, "R4 writes", wr_cnt, 1);
        chk(int'(band_out) == prev, "R4 band kept", int'(band_out), prev);
        repeat (10) @(negedge clk);
        chk(error == 1'b1, "R11 hold", int'(error), 1);
        chk(reg_we == 0 && reg_re == 0, "R4 no access", int'(reg_we), 0);

        // R11 cleared by next start, R1 read first
        run(5, 60, 1'b1, 1'b0, 16'h0F0F, lat);
        chk(error == 1'b0, "R11 cleared", int'(error), 0);
        chk(int'(band_out) == 4, "R5 after error", int'(band_out), 4);

        // R1 strobe timing
        @(negedge clk);
        cfg = 16'h4321; auto_en = 1'b1; auto_band = 6'd7;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(reg_re == 1'b1 && reg_we == 1'b0, "R1 read strobe", int'(reg_re), 1);
        @(negedge clk);
        chk(reg_re == 1'b0 && reg_we == 1'b0, "R1 wait", int'(reg_re), 0);
        @(negedge clk);
        chk(reg_we == 1'b1 && reg_wdata == 16'h43FD, "R2 auto word",
            int'(reg_wdata), 16'h43FD);
        repeat (20) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule